// File: doc/BRIEF.md
# Hot-Pluggable Processor Slot Register Block

This block is a compact memory-mapped register window through which firmware inspects and acknowledges changes on a fixed set of hot-pluggable processor slots. Software first stores a slot number in a 32-bit selector register. The status, command and data registers then operate on the state of the chosen slot. Each slot holds three flags: present/enabled, insertion pending and removal pending. Platform logic raises these flags through one-cycle request strobes, and software clears them by writing ones.

If the selector holds a number that is not a possible slot, the rest of the window is shut. Every read returns zero, and every write other than a selector write is dropped. This lasts until a valid number is stored again. The selector has its own power-on reset, which loads a valid slot number. The ordinary reset does not touch the selector. The ordinary reset clears the slot flags and the command and data registers.

Top module: `hpslot_regs`

## Requirements
- R1: The window covers byte addresses 0 to 11. A read at address 12 to 15 returns zero, and a write there changes no register.
- R2: Accesses are 32-bit words at the address with its two low bits ignored. Byte lane k of `wdata`/`rdata` (bits 8k+7:8k) maps to byte offset word+k, in little-endian order. A write updates only the lanes whose `be` bit is set.
- R3: Byte offsets 6 and 7, which are `rdata[31:16]` of the word at address 4, always read zero. Writes to them have no effect.
- R4: While the stored selector is not less than MAX_SLOTS, every read returns zero, including a read of the selector itself.
- R5: While the selector is invalid, writes to the words at addresses 4 and 8 are discarded. A write that makes the selector valid restores normal operation.
- R6: `por_n` low loads the selector with SEL_INIT. `rst_n` low leaves the selector unchanged. Either reset clears every slot flag, the command byte and the data word.
- R7: The selector validity check uses the full 32-bit value after the byte-enabled merge.
- R8: The status byte at offset 4 shows the selected slot's enabled flag in bit 0, insertion pending in bit 1 and removal pending in bit 2. Bits 3 to 7 read zero.
- R9: A pulse on `ins_req[i]` sets slot i's enabled and insertion-pending flags. A pulse on `rem_req[i]` sets slot i's removal-pending flag.
- R10: Writing 1 to status bit 0, 1 or 2 clears the selected slot's enabled, insertion-pending or removal-pending flag respectively. Writing 0 leaves the flag unchanged.
- R11: A request strobe in the same cycle as a software clear of the same flag leaves the flag set.
- R12: The command byte at offset 5 and the data word at offset 8 are read/write, with byte-enable control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low power-on reset, also loads the selector |
| rst_n | input | 1 | Asynchronous active-low reset, leaves the selector unchanged |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | 4 | Byte address into the window |
| be | input | 4 | Byte enables for the write lanes |
| wdata | input | 32 | Write data, little-endian lanes |
| rdata | output | 32 | Read data for `addr`, combinational |
| ins_req | input | MAX_SLOTS | One-cycle insertion request per slot |
| rem_req | input | MAX_SLOTS | One-cycle removal request per slot |

## Verification
The bench targets the following corner cases, each with the failure a faulty design would show:
- A selector made invalid by a partial write to an upper byte. A design that checked only the low byte would keep serving reads.
- Writes to status, command and data while the selector is invalid. A leaky gate would show the change once a valid selector is restored.
- A status clear that lands on the same edge as an insertion or removal strobe. A design that let the clear win would lose an event.
- A plain `rst_n` pulse after a non-zero selector. This exposes a selector wrongly tied to the ordinary reset.
- Reserved lanes and out-of-window addresses. Stray bits there would show up as non-zero read data or as registers that change.

// File: rtl/hpslot_pkg.sv
package hpslot_pkg;

  localparam int unsigned WIN_BYTES = 12;

  typedef enum logic [1:0] {
    W_SEL  = 2'd0,
    W_CTL  = 2'd1,
    W_DAT  = 2'd2,
    W_NONE = 2'd3
  } word_e;

  typedef struct packed {
    logic rem;
    logic ins;
    logic en;
  } slot_t;

  // byte-lane merge, lane k = byte offset k (little-endian)
  function automatic logic [31:0] lane_merge(input logic [31:0] old_v,
                                             input logic [31:0] new_v,
                                             input logic [3:0]  lanes);
    logic [31:0] r;
    r = old_v;
    for (int k = 0; k < 4; k++) begin
      if (lanes[k]) r[8*k +: 8] = new_v[8*k +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/hpslot_decode.sv
module hpslot_decode
  import hpslot_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output word_e             word
);

  logic in_win;

  always_comb begin
    in_win = (addr < ADDR_W'(WIN_BYTES));
    word   = in_win ? word_e'(addr[3:2]) : W_NONE;
  end

endmodule

// File: rtl/hpslot_slots.sv
module hpslot_slots
  import hpslot_pkg::*;
#(
  parameter int unsigned NSLOT = 8,
  localparam int unsigned IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] sel_idx,
  input  logic             clr_go,
  input  logic [2:0]       clr_bits,
  input  logic [NSLOT-1:0] ins_req,
  input  logic [NSLOT-1:0] rem_req,
  output logic [NSLOT-1:0] en_vec,
  output logic [NSLOT-1:0] ins_vec,
  output logic [NSLOT-1:0] rem_vec,
  output slot_t            cur
);

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic  hit;
    slot_t st_q, st_d;
    logic  st_ce;

    always_comb begin
      hit      = clr_go && (sel_idx == IDX_W'(g));
      st_d.en  = (st_q.en  & ~(hit & clr_bits[0])) | ins_req[g];
      st_d.ins = (st_q.ins & ~(hit & clr_bits[1])) | ins_req[g];
      st_d.rem = (st_q.rem & ~(hit & clr_bits[2])) | rem_req[g];
      st_ce    = hit | ins_req[g] | rem_req[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     st_q <= '0;
      else if (st_ce) st_q <= st_d;
    end

    assign en_vec[g]  = st_q.en;
    assign ins_vec[g] = st_q.ins;
    assign rem_vec[g] = st_q.rem;
  end

  always_comb begin
    cur = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (sel_idx == IDX_W'(i)) cur = '{rem: rem_vec[i], ins: ins_vec[i], en: en_vec[i]};
    end
  end

endmodule

// File: rtl/hpslot_regs.sv
module hpslot_regs
  import hpslot_pkg::*;
#(
  parameter int unsigned MAX_SLOTS = 8,
  parameter int unsigned SEL_INIT  = 0,
  localparam int unsigned IDX_W    = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [3:0]           addr,
  input  logic [3:0]           be,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  input  logic [MAX_SLOTS-1:0] ins_req,
  input  logic [MAX_SLOTS-1:0] rem_req
);

  word_e       word;
  logic        rst_all_n;
  logic [31:0] sel_q, sel_d;
  logic [7:0]  cmd_q, cmd_d;
  logic [31:0] data_q, data_d;
  logic        sel_ce, cmd_ce, data_ce;
  logic        sel_valid;
  logic        clr_go;
  logic [MAX_SLOTS-1:0] en_vec, ins_vec, rem_vec;
  slot_t       cur;

  assign rst_all_n = por_n & rst_n;
  assign sel_valid = (sel_q < 32'(MAX_SLOTS));

  hpslot_decode #(.ADDR_W(4)) u_dec (
    .addr (addr),
    .word (word)
  );

  hpslot_slots #(.NSLOT(MAX_SLOTS)) u_slots (
    .clk      (clk),
    .rst_n    (rst_all_n),
    .sel_idx  (sel_q[IDX_W-1:0]),
    .clr_go   (clr_go),
    .clr_bits (wdata[2:0]),
    .ins_req  (ins_req),
    .rem_req  (rem_req),
    .en_vec   (en_vec),
    .ins_vec  (ins_vec),
    .rem_vec  (rem_vec),
    .cur      (cur)
  );

  // next state and clock enables
  always_comb begin
    sel_ce  = wr_en && (word == W_SEL);
    cmd_ce  = wr_en && (word == W_CTL) && sel_valid && be[1];
    data_ce = wr_en && (word == W_DAT) && sel_valid;
    clr_go  = wr_en && (word == W_CTL) && sel_valid && be[0];
    sel_d   = lane_merge(sel_q, wdata, be);
    cmd_d   = wdata[15:8];
    data_d  = lane_merge(data_q, wdata, be);
  end

  // selector lives in the power-on domain only
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      sel_q <= 32'(SEL_INIT);
    else if (sel_ce) sel_q <= sel_d;
  end

  always_ff @(posedge clk or negedge rst_all_n) begin
    if (!rst_all_n) begin
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      if (cmd_ce)  cmd_q  <= cmd_d;
      if (data_ce) data_q <= data_d;
    end
  end

  // read path, blanked when the selector names no slot
  always_comb begin
    rdata = '0;
    if (sel_valid) begin
      unique case (word)
        W_SEL:   rdata = sel_q;
        W_CTL:   rdata = {16'h0000, cmd_q, 5'b00000, cur.rem, cur.ins, cur.en};
        W_DAT:   rdata = data_q;
        default: rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/hpslot_regs_chk.sv
module hpslot_regs_chk #(
  parameter int unsigned MAX_SLOTS = 8
) (
  input logic                 clk,
  input logic                 por_n,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [3:0]           addr,
  input logic [31:0]          rdata,
  input logic [MAX_SLOTS-1:0] ins_req,
  input logic [MAX_SLOTS-1:0] rem_req,
  input logic [31:0]          sel_q,
  input logic [7:0]           cmd_q,
  input logic [31:0]          data_q,
  input logic [MAX_SLOTS-1:0] en_vec,
  input logic [MAX_SLOTS-1:0] ins_vec,
  input logic [MAX_SLOTS-1:0] rem_vec
);

  logic bad_sel;
  assign bad_sel = (sel_q >= 32'(MAX_SLOTS));

  p_outside_zero_r1: assert property (@(posedge clk) disable iff (!por_n)
    (addr >= 4'd12) |-> (rdata == 32'h0));

  p_outside_nowrite_r1: assert property (@(posedge clk) disable iff (!(por_n && rst_n))
    (wr_en && addr >= 4'd12) |=> ($stable(sel_q) && $stable(cmd_q) && $stable(data_q)));

  p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!por_n)
    (addr[3:2] == 2'd1) |-> (rdata[31:16] == 16'h0));

  p_inval_read_zero_r4: assert property (@(posedge clk) disable iff (!por_n)
    bad_sel |-> (rdata == 32'h0));

  p_inval_write_drop_r5: assert property (@(posedge clk) disable iff (!(por_n && rst_n))
    (wr_en && bad_sel && addr[3:2] != 2'd0) |=> ($stable(cmd_q) && $stable(data_q)));

  p_sel_keep_r6: assert property (@(posedge clk) disable iff (!por_n)
    !(wr_en && addr[3:2] == 2'd0) |=> $stable(sel_q));

  p_status_pad_r8: assert property (@(posedge clk) disable iff (!por_n)
    (addr[3:2] == 2'd1) |-> (rdata[7:3] == 5'h0));

  p_ins_wins_r11: assert property (@(posedge clk) disable iff (!(por_n && rst_n))
    1'b1 |=> (((ins_vec & en_vec & $past(ins_req)) == $past(ins_req))));

  p_rem_wins_r11: assert property (@(posedge clk) disable iff (!(por_n && rst_n))
    1'b1 |=> ((rem_vec & $past(rem_req)) == $past(rem_req)));

endmodule

bind hpslot_regs hpslot_regs_chk #(.MAX_SLOTS(MAX_SLOTS)) u_chk (
  .clk     (clk),
  .por_n   (por_n),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .addr    (addr),
  .rdata   (rdata),
  .ins_req (ins_req),
  .rem_req (rem_req),
  .sel_q   (sel_q),
  .cmd_q   (cmd_q),
  .data_q  (data_q),
  .en_vec  (en_vec),
  .ins_vec (ins_vec),
  .rem_vec (rem_vec)
);

// File: tb/hpslot_regs_bench.sv
module hpslot_regs_bench;

  localparam int CLK_P    = 10;
  localparam int NS       = 8;
  localparam int SEL0     = 0;
  localparam int WDOG_CYC = 100000;

  logic          clk;
  logic          por_n, rst_n, wr_en;
  logic [3:0]    addr, be;
  logic [31:0]   wdata, rdata;
  logic [NS-1:0] ins_req, rem_req;

  int n_vec  = 0;
  int n_bad  = 0;
  bit done   = 0;

  // reference state
  logic [31:0]   m_sel, m_data;
  logic [7:0]    m_cmd;
  logic [NS-1:0] m_en, m_ins, m_rem;

  hpslot_regs #(.MAX_SLOTS(NS), .SEL_INIT(SEL0)) u_hpslot_regs (
    .clk (clk), .por_n (por_n), .rst_n (rst_n), .wr_en (wr_en),
    .addr (addr), .be (be), .wdata (wdata), .rdata (rdata),
    .ins_req (ins_req), .rem_req (rem_req)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] mrg(logic [31:0] o, logic [31:0] d, logic [3:0] b);
    logic [31:0] r = o;
    for (int k = 0; k < 4; k++) if (b[k]) r[8*k +: 8] = d[8*k +: 8];
    return r;
  endfunction

  function automatic logic [31:0] exp_read(logic [3:0] a);
    int s;
    if (m_sel >= 32'(NS) || a >= 4'd12) return 32'h0;
    s = int'(m_sel);
    case (a[3:2])
      2'd0:    return m_sel;
      2'd1:    return {16'h0, m_cmd, 5'h0, m_rem[s], m_ins[s], m_en[s]};
      default: return m_data;
    endcase
  endfunction

  task automatic model_step(logic w, logic [3:0] a, logic [3:0] b, logic [31:0] d,
                            logic [NS-1:0] ir, logic [NS-1:0] rr);
    logic ok;
    ok = (m_sel < 32'(NS));
    if (w && a < 4'd12) begin
      case (a[3:2])
        2'd0: m_sel = mrg(m_sel, d, b);
        2'd1: if (ok) begin
          if (b[0]) begin
            if (d[0]) m_en[int'(m_sel)]  = 1'b0;
            if (d[1]) m_ins[int'(m_sel)] = 1'b0;
            if (d[2]) m_rem[int'(m_sel)] = 1'b0;
          end
          if (b[1]) m_cmd = d[15:8];
        end
        default: if (ok) m_data = mrg(m_data, d, b);
      endcase
    end
    m_en  = m_en  | ir;
    m_ins = m_ins | ir;
    m_rem = m_rem | rr;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic w, logic [3:0] a, logic [3:0] b, logic [31:0] d,
                     logic [NS-1:0] ir, logic [NS-1:0] rr);
    @(negedge clk);
    wr_en = w; addr = a; be = b; wdata = d; ins_req = ir; rem_req = rr;
    @(posedge clk);
    model_step(w, a, b, d, ir, rr);
  endtask

  task automatic wr(logic [3:0] a, logic [3:0] b, logic [31:0] d);
    cyc(1'b1, a, b, d, '0, '0);
  endtask

  task automatic rd(logic [3:0] a, string tag);
    @(negedge clk);
    wr_en = 1'b0; addr = a; ins_req = '0; rem_req = '0;
    #1;
    check(tag, rdata, exp_read(a));
  endtask

  task automatic clear_model(logic keep_sel);
    if (!keep_sel) m_sel = 32'(SEL0);
    m_cmd = '0; m_data = '0; m_en = '0; m_ins = '0; m_rem = '0;
  endtask

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", WDOG_CYC, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7151));
    por_n = 1'b0; rst_n = 1'b0; wr_en = 1'b0; addr = '0; be = '0; wdata = '0;
    ins_req = '0; rem_req = '0;
    clear_model(1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk); por_n = 1'b1; rst_n = 1'b1;

    // R6: power-on state
    rd(4'd0, "R6 por selector");
    check("R6 por selector const", rdata, 32'(SEL0));
    rd(4'd4, "R6 por status");
    rd(4'd8, "R6 por data");

    // R9: request strobes set flags
    cyc(1'b0, 4'd0, 4'h0, 32'h0, 8'h01, 8'h00);
    rd(4'd4, "R9 insert sets en+ins");
    check("R9 insert const", rdata, 32'h3);
    cyc(1'b0, 4'd0, 4'h0, 32'h0, 8'h00, 8'h01);
    rd(4'd4, "R9 remove sets rem");
    check("R9 remove const", rdata, 32'h7);

    // R10: write-one-to-clear, zero leaves flags
    wr(4'd4, 4'h1, 32'h0);
    rd(4'd4, "R10 zero keeps flags");
    wr(4'd4, 4'h1, 32'h2);
    rd(4'd4, "R10 clear insert pending");
    check("R10 clear const", rdata, 32'h5);

    // R11: set beats clear on the same edge
    cyc(1'b1, 4'd4, 4'h1, 32'h7, 8'h01, 8'h01);
    rd(4'd4, "R11 set wins over clear");
    check("R11 const", rdata, 32'h7);

    // R8: status follows the selector, pad bits zero
    wr(4'd0, 4'hF, 32'd3);
    rd(4'd4, "R8 other slot empty");
    cyc(1'b0, 4'd0, 4'h0, 32'h0, 8'h08, 8'h00);
    rd(4'd4, "R8 slot3 layout");

    // R12 / R2: command and data with byte enables
    wr(4'd5, 4'h2, 32'h0000AB00);
    rd(4'd4, "R12 command byte");
    wr(4'd8, 4'hF, 32'h11223344);
    wr(4'd8, 4'h8, 32'hAA000000);
    rd(4'd8, "R2 top lane only");
    check("R2 const", rdata, 32'hAA223344);
    wr(4'd8, 4'h5, 32'h00EE00CC);
    rd(4'd8, "R12 lanes 0 and 2");

    // R3: reserved lanes
    wr(4'd4, 4'hC, 32'hFFFF0000);
    rd(4'd4, "R3 reserved reads zero");

    // R7 / R4: upper byte makes selector invalid
    wr(4'd0, 4'h4, 32'h00010000);
    rd(4'd0, "R7 full value checked");
    check("R4 selector blank", rdata, 32'h0);
    rd(4'd4, "R4 status blank");
    rd(4'd8, "R4 data blank");

    // R5: writes dropped while invalid, then restored
    wr(4'd8, 4'hF, 32'hDEADBEEF);
    wr(4'd5, 4'h2, 32'h00005500);
    wr(4'd4, 4'h1, 32'h7);
    wr(4'd0, 4'hF, 32'd3);
    rd(4'd8, "R5 data kept");
    rd(4'd4, "R5 status/command kept");

    // R1: out-of-window access
    wr(4'd12, 4'hF, 32'hFFFFFFFF);
    wr(4'd14, 4'hF, 32'h0);
    rd(4'd12, "R1 outside reads zero");
    rd(4'd0, "R1 selector untouched");
    rd(4'd8, "R1 data untouched");

    // R6: plain reset keeps selector
    wr(4'd0, 4'hF, 32'd5);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(posedge clk);
    clear_model(1'b1);
    @(negedge clk); rst_n = 1'b1;
    rd(4'd0, "R6 reset keeps selector");
    check("R6 selector const", rdata, 32'd5);
    rd(4'd8, "R6 reset clears data");

    // random mix
    for (int it = 0; it < 4000; it++) begin
      int kind;
      logic [NS-1:0] ir, rr;
      kind = int'($urandom % 10);
      ir = ($urandom % 4 == 0) ? NS'($urandom) : '0;
      rr = ($urandom % 4 == 0) ? NS'($urandom) : '0;
      if (kind < 2) begin
        logic [31:0] v;
        v = ($urandom % 4 == 0) ? $urandom : ($urandom % 10);
        cyc(1'b1, 4'd0, ($urandom % 3 == 0) ? 4'($urandom) : 4'hF, v, ir, rr);
      end else if (kind < 5) begin
        cyc(1'b1, 4'($urandom), 4'($urandom), $urandom, ir, rr);
      end else if (kind < 6) begin
        cyc(1'b0, 4'd0, 4'h0, 32'h0, ir, rr);
      end else begin
        rd(4'($urandom), "R2 R4 R8 R10 random read");
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule